// File: doc/BRIEF.md
# Banked Multiported Register File

This block is the physical register file of a four-issue datapath. Each of the four functional units sees a pair of operand read ports, one for the left source and one for the right source, so there are eight global read ports. Four global write ports carry results back. The storage is not one large array with twelve ports. It is split into four interleaved banks, and each bank has only two local read ports and two local write ports. A restricted crossbar connects the banks to the global buses. Local read port 0 of every bank feeds only the left-operand buses, and local read port 1 feeds only the right-operand buses. As a result, one instruction can always fetch both of its operands from the same bank in the same cycle.

Requests are expected to arrive already arbitrated. The block does not stall or buffer anything. When a cycle asks more of a bank than its local ports can give, the block serves a fixed subset of the requests and raises a conflict flag, so that logic upstream can repair the pipeline. Reads are combinational. Writes take effect on the rising clock edge, and a read of a register that is being written in the same cycle returns the value it held before the write. Forwarding belongs to the bypass network outside this block.

Top module: `bankrf_top`

## Requirements
- R1: A 6-bit register number selects a bank with bits [1:0] and a row inside that bank with bits [5:2]. Two reads on the same side conflict only when these two low bits are equal.
- R2: A write becomes visible after the rising clock edge. A read of the same register in the cycle of the write returns the old value.
- R3: Read data is combinational, and all eight read ports can return correct values in one cycle when the four left ports address four different banks and the four right ports address four different banks.
- R4: The left and right ports of one functional unit may address the same bank in one cycle. Both receive correct data and `rd_conflict_o` stays low.
- R5: When two or more enabled ports on the same side (left or right) address one bank, `rd_conflict_o` is 1. Only the lowest-numbered of those ports receives data, and the others return zero.
- R6: Up to two writes to one bank in one cycle all commit, and `wr_conflict_o` stays 0.
- R7: When three or more writes address one bank in one cycle, `wr_conflict_o` is 1 in that cycle. The two lowest-numbered of those writes commit, and the rest leave their registers unchanged.
- R8: When two committed writes in one cycle target the same register, the value from the higher-numbered write port is stored.
- R9: Reset clears every register to zero. With no requests, both conflict flags are 0.
- R10: A read port whose enable is 0 returns zero and does not count toward a read conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; clears all registers |
| rd_l_en_i | input | 4 | Enable, one bit per left-operand port |
| rd_l_addr_i | input | 24 | Left-operand register numbers, 6 bits per port, port 0 in the low bits |
| rd_l_data_o | output | 128 | Left-operand read data, 32 bits per port |
| rd_r_en_i | input | 4 | Enable, one bit per right-operand port |
| rd_r_addr_i | input | 24 | Right-operand register numbers, 6 bits per port |
| rd_r_data_o | output | 128 | Right-operand read data, 32 bits per port |
| wr_en_i | input | 4 | Enable, one bit per write port |
| wr_addr_i | input | 24 | Write register numbers, 6 bits per port |
| wr_data_i | input | 128 | Write data, 32 bits per port |
| rd_conflict_o | output | 1 | A local read port was asked for by more than one global port |
| wr_conflict_o | output | 1 | A bank received more than two writes |

## Verification
The hardest situation to reach is a write cycle that oversubscribes one bank while the other banks are also being written. Only in that cycle can the two-lowest-writers rule be told apart from a simple "drop everything" or "keep the last writes" rule. The bench therefore drives three writes into one bank plus one write into a different bank in a single cycle. It then reads back every target register, including the register of the write that was refused. Read conflicts are set up the same way, with colliding ports at non-adjacent indices, so that the priority direction can be seen at the ports.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
    // Every bank exposes this many local ports per direction.
    localparam int unsigned LOCAL_PORTS = 2;

    // Local read port index doubles as the operand side it serves.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;
endpackage

// File: rtl/bankrf_bank.sv
module bankrf_bank
    import bankrf_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx_i   [LOCAL_PORTS],
    output logic [DATA_W-1:0]      rd_data_o  [LOCAL_PORTS],
    input  logic [LOCAL_PORTS-1:0] wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i   [LOCAL_PORTS],
    input  logic [DATA_W-1:0]      wr_data_i  [LOCAL_PORTS]
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // Next state: slot order gives the later slot the final say.
    always_comb begin
        st_d = st_q;
        for (int s = 0; s < LOCAL_PORTS; s++) begin
            if (wr_en_i[s]) begin
                st_d.mem[wr_idx_i[s]] = wr_data_i[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Asynchronous read of the registered array.
    always_comb begin
        for (int s = 0; s < LOCAL_PORTS; s++) begin
            rd_data_o[s] = st_q.mem[rd_idx_i[s]];
        end
    end

    // R2
    wr_commit_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i[LOCAL_PORTS-1]
        |=> st_q.mem[$past(wr_idx_i[LOCAL_PORTS-1])] == $past(wr_data_i[LOCAL_PORTS-1]));

    // R2
    wr_commit_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i[0] && !(wr_en_i[LOCAL_PORTS-1] && (wr_idx_i[LOCAL_PORTS-1] == wr_idx_i[0])))
        |=> st_q.mem[$past(wr_idx_i[0])] == $past(wr_data_i[0]));
endmodule

// File: rtl/bankrf_wr_sel.sv
module bankrf_wr_sel
    import bankrf_pkg::*;
#(
    parameter int unsigned NUM_WR    = 4,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned IDX_W    = ADDR_W - BANK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WR-1:0]      wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i   [NUM_WR],
    input  logic [DATA_W-1:0]      wr_data_i   [NUM_WR],
    output logic [LOCAL_PORTS-1:0] bank_wen_o  [NUM_BANKS],
    output logic [IDX_W-1:0]       bank_widx_o [NUM_BANKS][LOCAL_PORTS],
    output logic [DATA_W-1:0]      bank_wdata_o[NUM_BANKS][LOCAL_PORTS],
    output logic [NUM_WR-1:0]      wr_granted_o,
    output logic                   wr_conflict_o
);
    logic [NUM_BANKS-1:0] bank_over;

    // Fill each bank's slots in write-port order; extra writers get no slot.
    always_comb begin
        wr_granted_o = '0;
        bank_over    = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            int unsigned fill;
            fill = 0;
            bank_wen_o[b] = '0;
            for (int s = 0; s < LOCAL_PORTS; s++) begin
                bank_widx_o[b][s]  = '0;
                bank_wdata_o[b][s] = '0;
            end
            for (int w = 0; w < NUM_WR; w++) begin
                if (wr_en_i[w] && (wr_addr_i[w][BANK_W-1:0] == BANK_W'(b))) begin
                    for (int s = 0; s < LOCAL_PORTS; s++) begin
                        if (fill == s) begin
                            bank_wen_o[b][s]   = 1'b1;
                            bank_widx_o[b][s]  = wr_addr_i[w][ADDR_W-1:BANK_W];
                            bank_wdata_o[b][s] = wr_data_i[w];
                            wr_granted_o[w]    = 1'b1;
                        end
                    end
                    if (fill >= LOCAL_PORTS) begin
                        bank_over[b] = 1'b1;
                    end
                    fill = fill + 1;
                end
            end
        end
        wr_conflict_o = |bank_over;
    end

    // R6
    wr_all_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_conflict_o |-> (wr_granted_o == wr_en_i));

    // R7
    wr_some_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_conflict_o |-> ($countones(wr_granted_o) < $countones(wr_en_i)));

    // R7
    wr_granted_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_granted_o & ~wr_en_i) == '0);
endmodule

// File: rtl/bankrf_rd_xbar.sv
module bankrf_rd_xbar #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned IDX_W    = ADDR_W - BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] rd_en_i,
    input  logic [ADDR_W-1:0]    rd_addr_i    [NUM_PORTS],
    input  logic [DATA_W-1:0]    bank_rdata_i [NUM_BANKS],
    output logic [IDX_W-1:0]     bank_ridx_o  [NUM_BANKS],
    output logic [DATA_W-1:0]    rd_data_o    [NUM_PORTS],
    output logic                 rd_conflict_o
);
    logic [NUM_PORTS-1:0] grant_mat [NUM_BANKS];
    logic [NUM_PORTS-1:0] granted;
    logic [NUM_BANKS-1:0] bank_over;

    // One local port per bank on this side: lowest-numbered requester wins.
    always_comb begin
        bank_over = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            logic taken;
            taken = 1'b0;
            grant_mat[b]   = '0;
            bank_ridx_o[b] = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (rd_en_i[p] && (rd_addr_i[p][BANK_W-1:0] == BANK_W'(b))) begin
                    if (!taken) begin
                        grant_mat[b][p] = 1'b1;
                        bank_ridx_o[b]  = rd_addr_i[p][ADDR_W-1:BANK_W];
                        taken           = 1'b1;
                    end else begin
                        bank_over[b] = 1'b1;
                    end
                end
            end
        end
        rd_conflict_o = |bank_over;
    end

    // Route bank data back onto the global buses of granted ports.
    always_comb begin
        granted = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            granted = granted | grant_mat[b];
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            rd_data_o[p] = granted[p] ? bank_rdata_i[rd_addr_i[p][BANK_W-1:0]] : '0;
        end
    end

    generate
        for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank_chk
            // R5
            rd_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(grant_mat[gb]));
        end
        for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port_chk
            // R10
            rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en_i[gp] |-> (rd_data_o[gp] == '0));
        end
    endgenerate

    // R5
    rd_conflict_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_conflict_o |-> (granted != rd_en_i));
endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
    import bankrf_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 64,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_FU    = 4,
    parameter int unsigned NUM_WR    = 4,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned ADDR_W   = $clog2(NUM_REGS),
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned DEPTH    = NUM_REGS / NUM_BANKS,
    localparam int unsigned IDX_W    = ADDR_W - BANK_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_FU-1:0]          rd_l_en_i,
    input  logic [NUM_FU*ADDR_W-1:0]   rd_l_addr_i,
    output logic [NUM_FU*DATA_W-1:0]   rd_l_data_o,
    input  logic [NUM_FU-1:0]          rd_r_en_i,
    input  logic [NUM_FU*ADDR_W-1:0]   rd_r_addr_i,
    output logic [NUM_FU*DATA_W-1:0]   rd_r_data_o,
    input  logic [NUM_WR-1:0]          wr_en_i,
    input  logic [NUM_WR*ADDR_W-1:0]   wr_addr_i,
    input  logic [NUM_WR*DATA_W-1:0]   wr_data_i,
    output logic                       rd_conflict_o,
    output logic                       wr_conflict_o
);
    localparam int unsigned NUM_SIDES = LOCAL_PORTS;

    // Unpacked views of the flattened buses, indexed by side.
    logic [NUM_FU-1:0]   side_en    [NUM_SIDES];
    logic [ADDR_W-1:0]   side_addr  [NUM_SIDES][NUM_FU];
    logic [DATA_W-1:0]   side_data  [NUM_SIDES][NUM_FU];
    logic [IDX_W-1:0]    side_ridx  [NUM_SIDES][NUM_BANKS];
    logic [DATA_W-1:0]   side_rdata [NUM_SIDES][NUM_BANKS];
    logic [NUM_SIDES-1:0] side_conf;

    logic [IDX_W-1:0]    bank_ridx  [NUM_BANKS][LOCAL_PORTS];
    logic [DATA_W-1:0]   bank_rdata [NUM_BANKS][LOCAL_PORTS];

    logic [ADDR_W-1:0]      w_addr [NUM_WR];
    logic [DATA_W-1:0]      w_data [NUM_WR];
    logic [LOCAL_PORTS-1:0] bank_wen   [NUM_BANKS];
    logic [IDX_W-1:0]       bank_widx  [NUM_BANKS][LOCAL_PORTS];
    logic [DATA_W-1:0]      bank_wdata [NUM_BANKS][LOCAL_PORTS];
    logic [NUM_WR-1:0]      wr_granted;

    always_comb begin
        side_en[SIDE_LEFT]  = rd_l_en_i;
        side_en[SIDE_RIGHT] = rd_r_en_i;
        for (int p = 0; p < NUM_FU; p++) begin
            side_addr[SIDE_LEFT][p]  = rd_l_addr_i[p*ADDR_W +: ADDR_W];
            side_addr[SIDE_RIGHT][p] = rd_r_addr_i[p*ADDR_W +: ADDR_W];
        end
        for (int w = 0; w < NUM_WR; w++) begin
            w_addr[w] = wr_addr_i[w*ADDR_W +: ADDR_W];
            w_data[w] = wr_data_i[w*DATA_W +: DATA_W];
        end
    end

    // Local read port s of every bank is wired to side s only.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int s = 0; s < NUM_SIDES; s++) begin
                bank_ridx[b][s]  = side_ridx[s][b];
                side_rdata[s][b] = bank_rdata[b][s];
            end
        end
    end

    generate
        for (genvar gs = 0; gs < NUM_SIDES; gs++) begin : g_side
            bankrf_rd_xbar #(
                .NUM_PORTS (NUM_FU),
                .NUM_BANKS (NUM_BANKS),
                .ADDR_W    (ADDR_W),
                .DATA_W    (DATA_W)
            ) u_xbar (
                .clk           (clk),
                .rst_n         (rst_n),
                .rd_en_i       (side_en[gs]),
                .rd_addr_i     (side_addr[gs]),
                .bank_rdata_i  (side_rdata[gs]),
                .bank_ridx_o   (side_ridx[gs]),
                .rd_data_o     (side_data[gs]),
                .rd_conflict_o (side_conf[gs])
            );
        end

        for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            bankrf_bank #(
                .DEPTH  (DEPTH),
                .DATA_W (DATA_W)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .rd_idx_i  (bank_ridx[gb]),
                .rd_data_o (bank_rdata[gb]),
                .wr_en_i   (bank_wen[gb]),
                .wr_idx_i  (bank_widx[gb]),
                .wr_data_i (bank_wdata[gb])
            );
        end
    endgenerate

    bankrf_wr_sel #(
        .NUM_WR    (NUM_WR),
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_wr_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (w_addr),
        .wr_data_i     (w_data),
        .bank_wen_o    (bank_wen),
        .bank_widx_o   (bank_widx),
        .bank_wdata_o  (bank_wdata),
        .wr_granted_o  (wr_granted),
        .wr_conflict_o (wr_conflict_o)
    );

    always_comb begin
        for (int p = 0; p < NUM_FU; p++) begin
            rd_l_data_o[p*DATA_W +: DATA_W] = side_data[SIDE_LEFT][p];
            rd_r_data_o[p*DATA_W +: DATA_W] = side_data[SIDE_RIGHT][p];
        end
        rd_conflict_o = |side_conf;
    end

    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_l_en_i == '0) && (rd_r_en_i == '0)) |-> !rd_conflict_o);

    // R9
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i == '0) |-> (!wr_conflict_o && (wr_granted == '0)));
endmodule

// File: tb/bankrf_top_tb.sv
`timescale 1ns/1ps
module bankrf_top_tb;
    localparam int NF = 4;
    localparam int NW = 4;
    localparam int AW = 6;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NF-1:0]    rd_l_en, rd_r_en;
    logic [NF*AW-1:0] rd_l_addr, rd_r_addr;
    logic [NF*DW-1:0] rd_l_data, rd_r_data;
    logic [NW-1:0]    wr_en;
    logic [NW*AW-1:0] wr_addr;
    logic [NW*DW-1:0] wr_data;
    logic rd_conf, wr_conf;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] ref_q [64];

    always #2.5 clk = ~clk;

    bankrf_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_l_en_i(rd_l_en), .rd_l_addr_i(rd_l_addr), .rd_l_data_o(rd_l_data),
        .rd_r_en_i(rd_r_en), .rd_r_addr_i(rd_r_addr), .rd_r_data_o(rd_r_data),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_conflict_o(rd_conf), .wr_conflict_o(wr_conf)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_l_en = '0; rd_r_en = '0; wr_en = '0;
        rd_l_addr = '0; rd_r_addr = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd_l(input int p, input int r, input bit en);
        rd_l_en[p] = en;
        rd_l_addr[p*AW +: AW] = AW'(r);
    endtask

    task automatic rd_r(input int p, input int r, input bit en);
        rd_r_en[p] = en;
        rd_r_addr[p*AW +: AW] = AW'(r);
    endtask

    task automatic wr(input int p, input int r, input logic [DW-1:0] d);
        wr_en[p] = 1'b1;
        wr_addr[p*AW +: AW] = AW'(r);
        wr_data[p*DW +: DW] = d;
    endtask

    function automatic logic [DW-1:0] ld(input int p);
        return rd_l_data[p*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] rdr(input int p);
        return rd_r_data[p*DW +: DW];
    endfunction

    // Drive writes already set up at a negedge through one rising edge.
    task automatic commit();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic t_reset();
        for (int r = 0; r < 64; r++) begin
            @(negedge clk);
            idle();
            rd_l(r % NF, r, 1'b1);
            #1;
            chk("R9 reset contents", ld(r % NF), '0);
        end
        idle();
        #1;
        chk("R9 rd_conflict idle", {31'd0, rd_conf}, 0);
        chk("R9 wr_conflict idle", {31'd0, wr_conf}, 0);
    endtask

    task automatic t_parallel();
        @(negedge clk);
        idle();
        for (int i = 0; i < 4; i++) begin
            wr(i, 16 + i, 32'hA000_0000 + DW'(i));
            ref_q[16 + i] = 32'hA000_0000 + DW'(i);
        end
        #1;
        chk("R6 four banks no wr_conflict", {31'd0, wr_conf}, 0);
        commit();
        @(negedge clk);
        for (int p = 0; p < NF; p++) begin
            rd_l(p, 16 + p, 1'b1);
            rd_r(p, 19 - p, 1'b1);
        end
        #1;
        for (int p = 0; p < NF; p++) begin
            chk("R3 left port data", ld(p), ref_q[16 + p]);
            chk("R3 right port data", rdr(p), ref_q[19 - p]);
        end
        chk("R1 R3 distinct banks no rd_conflict", {31'd0, rd_conf}, 0);
        idle();
    endtask

    task automatic t_rw_same();
        @(negedge clk);
        idle();
        wr(0, 17, 32'hBEEF_0017);
        rd_l(0, 17, 1'b1);
        #1;
        chk("R2 same-cycle read returns old", ld(0), ref_q[17]);
        @(posedge clk);
        #1;
        ref_q[17] = 32'hBEEF_0017;
        wr_en = '0;
        #0.5;
        chk("R2 read after edge returns new", ld(0), ref_q[17]);
        idle();
    endtask

    task automatic t_same_fu();
        @(negedge clk);
        idle();
        rd_l(1, 16, 1'b1);
        rd_r(1, 20, 1'b1);
        #1;
        chk("R4 left operand same bank", ld(1), ref_q[16]);
        chk("R4 right operand same bank", rdr(1), ref_q[20]);
        chk("R4 no rd_conflict", {31'd0, rd_conf}, 0);
        idle();
    endtask

    task automatic t_rd_conflict();
        @(negedge clk);
        idle();
        rd_l(0, 17, 1'b1);
        rd_l(2, 21, 1'b1);
        #1;
        chk("R5 left conflict flag", {31'd0, rd_conf}, 1);
        chk("R5 left lowest port served", ld(0), ref_q[17]);
        chk("R5 left loser returns zero", ld(2), '0);
        @(negedge clk);
        idle();
        rd_r(3, 18, 1'b1);
        rd_r(1, 22, 1'b1);
        #1;
        chk("R5 right conflict flag", {31'd0, rd_conf}, 1);
        chk("R5 right lowest port served", rdr(1), ref_q[22]);
        chk("R5 right loser returns zero", rdr(3), '0);
        @(negedge clk);
        idle();
        rd_l(0, 16, 1'b1);
        rd_l(1, 17, 1'b1);
        #1;
        chk("R1 adjacent registers differ in bank", {31'd0, rd_conf}, 0);
        chk("R1 bank0 data", ld(0), ref_q[16]);
        chk("R1 bank1 data", ld(1), ref_q[17]);
        idle();
    endtask

    task automatic t_two_writes();
        @(negedge clk);
        idle();
        wr(1, 3, 32'hB100_0003);
        wr(2, 7, 32'hB200_0007);
        #1;
        chk("R6 two writes one bank no conflict", {31'd0, wr_conf}, 0);
        commit();
        ref_q[3] = 32'hB100_0003;
        ref_q[7] = 32'hB200_0007;
        @(negedge clk);
        rd_l(0, 3, 1'b1);
        rd_r(0, 7, 1'b1);
        #1;
        chk("R6 first write committed", ld(0), ref_q[3]);
        chk("R6 second write committed", rdr(0), ref_q[7]);
        idle();
    endtask

    task automatic t_three_writes();
        @(negedge clk);
        idle();
        wr(0, 0, 32'hC000_0000);
        wr(1, 4, 32'hC100_0004);
        wr(2, 1, 32'hC200_0001);
        wr(3, 8, 32'hC300_0008);
        #1;
        chk("R7 wr_conflict raised", {31'd0, wr_conf}, 1);
        commit();
        ref_q[0] = 32'hC000_0000;
        ref_q[4] = 32'hC100_0004;
        ref_q[1] = 32'hC200_0001;
        @(negedge clk);
        rd_l(0, 0, 1'b1);
        rd_r(0, 4, 1'b1);
        rd_l(1, 1, 1'b1);
        rd_r(1, 8, 1'b1);
        #1;
        chk("R7 lowest writer committed", ld(0), ref_q[0]);
        chk("R7 second writer committed", rdr(0), ref_q[4]);
        chk("R7 other bank write committed", ld(1), ref_q[1]);
        chk("R7 refused write left register", rdr(1), ref_q[8]);
        chk("R7 conflict cleared next cycle", {31'd0, wr_conf}, 0);
        idle();
    endtask

    task automatic t_same_reg();
        @(negedge clk);
        idle();
        wr(0, 9, 32'hD000_0009);
        wr(2, 9, 32'hD200_0009);
        #1;
        chk("R8 no conflict", {31'd0, wr_conf}, 0);
        commit();
        ref_q[9] = 32'hD200_0009;
        @(negedge clk);
        rd_r(2, 9, 1'b1);
        #1;
        chk("R8 higher port wins", rdr(2), ref_q[9]);
        idle();
    endtask

    task automatic t_disabled();
        @(negedge clk);
        idle();
        rd_l(0, 20, 1'b0);
        rd_l(1, 16, 1'b1);
        rd_r(2, 17, 1'b0);
        #1;
        chk("R10 disabled left returns zero", ld(0), '0);
        chk("R10 disabled right returns zero", rdr(2), '0);
        chk("R10 disabled port no conflict", {31'd0, rd_conf}, 0);
        chk("R10 enabled neighbour served", ld(1), ref_q[16]);
        idle();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int r = 0; r < 64; r++) ref_q[r] = '0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_parallel();
        t_rw_same();
        t_same_fu();
        t_rd_conflict();
        t_two_writes();
        t_three_writes();
        t_same_reg();
        t_disabled();
        summary();
        $finish;
    end
endmodule